// File: doc/BRIEF.md
# Asynchronous SRAM Timing Controller

This block sits between a clocked host bus and an asynchronous 16-bit static RAM. It serves one request at a time, either a read or a write. It produces the memory's address, chip-select, output-enable, write-enable and byte-lane strobes as registered, glitch-free levels. Each phase lasts a whole number of clock cycles. That number is the ceiling of the memory's nanosecond limit divided by the clock period.

The host raises `req_valid` with the command fields and holds all of them steady until `req_ack` pulses. For a read, `rsp_rdata` carries the result from that pulse onwards and keeps it until the next read completes. After every read the controller inserts an idle gap, so it never drives the shared data pins while the memory may still be releasing them.

A request whose lane mask is empty is completed at once and the memory is not touched.

Top module: `asram_ctrl`

## Requirements
- R1: While reset is held, and after it is released with no request pending, `mem_cs_n`=1, `mem_cs`=0, `mem_oe_n`=1, `mem_we_n`=1, `mem_drive`=0, `mem_be_n`=2'b11 and `req_ack`=0.
- R2: A read (`req_write`=0, non-empty mask) is accepted on the first clock edge at which the controller is idle, `req_valid`=1 and `req_ack`=0. From that edge, address, both chip selects and `mem_oe_n`=0 stay asserted for N_RD = max(2, ceil(T_RC/CLK), ceil(T_AA/CLK), ceil(T_OE/CLK)) cycles. `mem_din` is sampled on the edge that ends this window, and `req_ack` rises on that same edge. With the default 20 ns clock this is the 5th edge after acceptance.
- R3: In `rsp_rdata`, a lane whose byte enable was active during the read holds the memory data. A disabled lane reads as zero. The value is held until the next read completes and is not changed by writes.
- R4: A write (`req_write`=1) drives address, data (`mem_drive`=1) and chip selects for one setup cycle with `mem_we_n`=1. Then `mem_we_n`=0 for N_WP = max(1, ceil(T_WP/CLK), ceil(T_DW/CLK), ceil(T_AW/CLK)-1) cycles. Then follow max(1, ceil(T_WC/CLK)-1-N_WP) recovery cycles, and `req_ack` rises when these end. `mem_oe_n` stays 1 for the whole write.
- R5: Mask bit i set gives `mem_be_n[i]`=0 for the whole access. Lane 0 is data bits 7:0 and lane 1 is bits 15:8.
- R6: A request with mask 2'b00 raises `req_ack` on the edge after acceptance. It asserts no chip select, output enable or write enable, and memory contents do not change.
- R7: `req_ack` is high for exactly one cycle per request. No new request is accepted while it is high.
- R8: After a read, `mem_drive` does not rise until `mem_oe_n` has been high for at least ceil(T_HZ/CLK) cycles.
- R9: While the chip is selected, `mem_addr` does not change. While `mem_drive`=1, `mem_dout` does not change. Every access keeps the chip selected for at least the read or write cycle time.
- R10: All limits are nanosecond parameters together with the clock period. Every cycle count above is derived from them by ceiling division.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| req_mask | input | LANES | Byte-lane select, bit 0 = bits 7:0 |
| req_ack | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DATA_W | Read result, disabled lanes zero |
| mem_addr | output | ADDR_W | Memory address |
| mem_dout | output | DATA_W | Data toward memory |
| mem_drive | output | 1 | Data pin drive enable |
| mem_cs_n | output | 1 | Active-low chip select |
| mem_cs | output | 1 | Active-high chip select |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_we_n | output | 1 | Active-low write enable |
| mem_be_n | output | LANES | Active-low byte enables |
| mem_din | input | DATA_W | Data from memory |

## Verification
The embedded properties assume that the host keeps the request fields constant from `req_valid` until the acknowledge pulse, and that it drops `req_valid` right after that pulse. The bench's request task follows exactly this pattern. A behavioural memory in the bench time-stamps every pin edge. It returns inverted data if a capture could come before the access limits, and it counts write-pulse, setup, cycle-length and turnaround violations. The stimulus uses only legal host sequences, both with idle gaps and back to back, so that any mismatch points at the controller's timing.

// File: rtl/asram_pkg.sv
`timescale 1ns/1ps
package asram_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_ACC,
    ST_RD_CAP,
    ST_WR_SET,
    ST_WR_PUL,
    ST_WR_END,
    ST_TURN
  } seq_state_e;

  function automatic int ns2cyc(input int ns, input int clk_ns);
    return (ns + clk_ns - 1) / clk_ns;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/asram_rst_sync.sv
`timescale 1ns/1ps
module asram_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_sync
);
  logic stage_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      stage_q    <= 1'b0;
      rst_n_sync <= 1'b0;
    end else begin
      stage_q    <= 1'b1;
      rst_n_sync <= stage_q;
    end
  end
endmodule

// File: rtl/asram_cycle_timer.sv
`timescale 1ns/1ps
module asram_cycle_timer #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             done
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load || (cnt_q != '0);
    cnt_d  = load ? load_val : cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign done = (cnt_q == '0);
endmodule

// File: rtl/asram_seq.sv
`timescale 1ns/1ps
module asram_seq
  import asram_pkg::*;
#(
  parameter int CNT_W = 3,
  parameter int N_RD  = 5,
  parameter int N_WP  = 3,
  parameter int N_WE  = 1,
  parameter int N_HZ  = 2,
  parameter int LANES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [LANES-1:0] req_mask,
  input  logic             tdone,
  output seq_state_e       state_nxt,
  output logic             accept,
  output logic             capture,
  output logic             ack_q,
  output logic             t_load,
  output logic [CNT_W-1:0] t_val
);
  localparam logic [CNT_W-1:0] V_RD = CNT_W'(N_RD - 2);
  localparam logic [CNT_W-1:0] V_WP = CNT_W'(N_WP - 1);
  localparam logic [CNT_W-1:0] V_WE = CNT_W'(N_WE - 1);
  localparam logic [CNT_W-1:0] V_HZ = CNT_W'(N_HZ - 1);

  seq_state_e state_q;
  logic       finish;

  always_comb begin
    state_nxt = state_q;
    accept    = 1'b0;
    capture   = 1'b0;
    finish    = 1'b0;
    t_load    = 1'b0;
    t_val     = '0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid && !ack_q) begin
          accept = 1'b1;
          if (req_mask == '0) begin
            finish = 1'b1;
          end else if (req_write) begin
            state_nxt = ST_WR_SET;
            t_load    = 1'b1;
          end else begin
            state_nxt = ST_RD_ACC;
            t_load    = 1'b1;
            t_val     = V_RD;
          end
        end
      end
      ST_RD_ACC: begin
        if (tdone) begin
          state_nxt = ST_RD_CAP;
          t_load    = 1'b1;
        end
      end
      ST_RD_CAP: begin
        capture   = 1'b1;
        finish    = 1'b1;
        state_nxt = ST_TURN;
        t_load    = 1'b1;
        t_val     = V_HZ;
      end
      ST_WR_SET: begin
        state_nxt = ST_WR_PUL;
        t_load    = 1'b1;
        t_val     = V_WP;
      end
      ST_WR_PUL: begin
        if (tdone) begin
          state_nxt = ST_WR_END;
          t_load    = 1'b1;
          t_val     = V_WE;
        end
      end
      ST_WR_END: begin
        if (tdone) begin
          state_nxt = ST_IDLE;
          finish    = 1'b1;
        end
      end
      ST_TURN: begin
        if (tdone) state_nxt = ST_IDLE;
      end
      default: state_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ack_q   <= 1'b0;
    end else begin
      state_q <= state_nxt;
      ack_q   <= finish;
    end
  end

  // R7
  ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_q |=> !ack_q);

  // R7
  ack_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_q |-> !capture);
endmodule

// File: rtl/asram_pins.sv
`timescale 1ns/1ps
module asram_pins
  import asram_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 16,
  parameter int LANES  = 2,
  parameter int N_WP   = 3,
  parameter int N_HZ   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  seq_state_e        state_nxt,
  input  logic              accept,
  input  logic              capture,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [LANES-1:0]  req_mask,
  input  logic [DATA_W-1:0] mem_din,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dout,
  output logic              mem_drive,
  output logic              mem_cs_n,
  output logic              mem_cs,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [LANES-1:0]  mem_be_n,
  output logic [DATA_W-1:0] rsp_rdata
);
  localparam int LANE_W = DATA_W / LANES;
  localparam int WC_W   = $clog2(N_WP + 2);
  localparam int OC_W   = $clog2(N_HZ + 2);

  logic              ce_on, oe_on, we_on, drv_on;
  logic [DATA_W-1:0] cap_val;

  always_comb begin
    ce_on  = (state_nxt == ST_RD_ACC) || (state_nxt == ST_RD_CAP) ||
             (state_nxt == ST_WR_SET) || (state_nxt == ST_WR_PUL) ||
             (state_nxt == ST_WR_END);
    oe_on  = (state_nxt == ST_RD_ACC) || (state_nxt == ST_RD_CAP);
    we_on  = (state_nxt == ST_WR_PUL);
    drv_on = (state_nxt == ST_WR_SET) || (state_nxt == ST_WR_PUL) ||
             (state_nxt == ST_WR_END);
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign cap_val[g*LANE_W +: LANE_W] =
      mem_be_n[g] ? '0 : mem_din[g*LANE_W +: LANE_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_cs_n  <= 1'b1;
      mem_cs    <= 1'b0;
      mem_oe_n  <= 1'b1;
      mem_we_n  <= 1'b1;
      mem_drive <= 1'b0;
    end else begin
      mem_cs_n  <= !ce_on;
      mem_cs    <= ce_on;
      mem_oe_n  <= !oe_on;
      mem_we_n  <= !we_on;
      mem_drive <= drv_on;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      mem_be_n <= '1;
    else if (!ce_on) mem_be_n <= '1;
    else if (accept) mem_be_n <= ~req_mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_addr <= '0;
      mem_dout <= '0;
    end else if (accept) begin
      mem_addr <= req_addr;
      mem_dout <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rsp_rdata <= '0;
    else if (capture) rsp_rdata <= cap_val;
  end

  // checker counters: write-pulse length and output-enable idle time
  logic [WC_W-1:0] wlow_cnt;
  logic [OC_W-1:0] oe_off_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              wlow_cnt <= '0;
    else if (mem_we_n)       wlow_cnt <= '0;
    else if (wlow_cnt != '1) wlow_cnt <= wlow_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                oe_off_cnt <= '1;
    else if (!mem_oe_n)        oe_off_cnt <= '0;
    else if (oe_off_cnt != '1) oe_off_cnt <= oe_off_cnt + 1'b1;
  end

  // R4
  we_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (wlow_cnt >= WC_W'(N_WP)));

  // R4
  oe_write_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_oe_n && (!mem_we_n || mem_drive)));

  // R8
  turn_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_drive) |-> (oe_off_cnt >= OC_W'(N_HZ)));

  // R9
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_cs_n && $past(!mem_cs_n)) |-> (mem_addr == $past(mem_addr)));

  // R9
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_drive && $past(mem_drive)) |-> $stable(mem_dout));

  // R5
  be_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_cs_n |-> (mem_be_n == '1));
endmodule

// File: rtl/asram_ctrl.sv
`timescale 1ns/1ps
module asram_ctrl
  import asram_pkg::*;
#(
  parameter int CLK_NS  = 20,
  parameter int T_RC_NS = 85,
  parameter int T_AA_NS = 85,
  parameter int T_OE_NS = 35,
  parameter int T_WC_NS = 85,
  parameter int T_WP_NS = 60,
  parameter int T_DW_NS = 40,
  parameter int T_AW_NS = 70,
  parameter int T_HZ_NS = 30,
  parameter int ADDR_W  = 18,
  parameter int DATA_W  = 16,
  parameter int LANES   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [LANES-1:0]  req_mask,
  output logic              req_ack,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dout,
  output logic              mem_drive,
  output logic              mem_cs_n,
  output logic              mem_cs,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [LANES-1:0]  mem_be_n,
  input  logic [DATA_W-1:0] mem_din
);
  // R10: phase lengths by ceiling division of each limit
  localparam int N_RD = imax(2, imax(ns2cyc(T_RC_NS, CLK_NS),
                          imax(ns2cyc(T_AA_NS, CLK_NS), ns2cyc(T_OE_NS, CLK_NS))));
  localparam int N_WP = imax(1, imax(ns2cyc(T_WP_NS, CLK_NS),
                          imax(ns2cyc(T_DW_NS, CLK_NS), ns2cyc(T_AW_NS, CLK_NS) - 1)));
  localparam int N_WE = imax(1, ns2cyc(T_WC_NS, CLK_NS) - 1 - N_WP);
  localparam int N_HZ = imax(1, ns2cyc(T_HZ_NS, CLK_NS));
  localparam int CNT_MAX = imax(imax(N_RD, N_WP), imax(N_WE, N_HZ));
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  logic             srst_n;
  seq_state_e       st_nxt;
  logic             accept, capture, t_load, tdone;
  logic [CNT_W-1:0] t_val;

  asram_rst_sync u_rst (
    .clk        (clk),
    .arst_n     (rst_n),
    .rst_n_sync (srst_n)
  );

  asram_cycle_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk      (clk),
    .rst_n    (srst_n),
    .load     (t_load),
    .load_val (t_val),
    .done     (tdone)
  );

  asram_seq #(
    .CNT_W (CNT_W), .N_RD (N_RD), .N_WP (N_WP),
    .N_WE  (N_WE),  .N_HZ (N_HZ), .LANES (LANES)
  ) u_seq (
    .clk       (clk),
    .rst_n     (srst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_mask  (req_mask),
    .tdone     (tdone),
    .state_nxt (st_nxt),
    .accept    (accept),
    .capture   (capture),
    .ack_q     (req_ack),
    .t_load    (t_load),
    .t_val     (t_val)
  );

  asram_pins #(
    .ADDR_W (ADDR_W), .DATA_W (DATA_W), .LANES (LANES),
    .N_WP   (N_WP),   .N_HZ   (N_HZ)
  ) u_pins (
    .clk       (clk),
    .rst_n     (srst_n),
    .state_nxt (st_nxt),
    .accept    (accept),
    .capture   (capture),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .req_mask  (req_mask),
    .mem_din   (mem_din),
    .mem_addr  (mem_addr),
    .mem_dout  (mem_dout),
    .mem_drive (mem_drive),
    .mem_cs_n  (mem_cs_n),
    .mem_cs    (mem_cs),
    .mem_oe_n  (mem_oe_n),
    .mem_we_n  (mem_we_n),
    .mem_be_n  (mem_be_n),
    .rsp_rdata (rsp_rdata)
  );
endmodule

// File: tb/sim_asram_ctrl.sv
`timescale 1ns/1ps
module sim_asram_ctrl;
  localparam int AW = 6;
  localparam int DEPTH = 1 << AW;
  localparam int CLK = 20;

  function automatic int cdiv(input int n); return (n + CLK - 1) / CLK; endfunction
  function automatic int mx(input int a, input int b); return a > b ? a : b; endfunction

  // R10: expected phase lengths from the stated formulas
  localparam int EXP_RD  = mx(2, mx(cdiv(85), mx(cdiv(85), cdiv(35))));
  localparam int EXP_WP  = mx(1, mx(cdiv(60), mx(cdiv(40), cdiv(70) - 1)));
  localparam int EXP_WE  = mx(1, cdiv(85) - 1 - EXP_WP);
  localparam int LAT_RD  = EXP_RD + 1;
  localparam int LAT_WR  = 1 + EXP_WP + EXP_WE + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0] req_mask = '0;
  logic req_ack;
  logic [15:0] rsp_rdata, mem_dout, din_q;
  logic [AW-1:0] mem_addr;
  logic mem_drive, mem_cs_n, mem_cs, mem_oe_n, mem_we_n;
  logic [1:0] mem_be_n;

  always #10 clk = ~clk;

  asram_ctrl #(.ADDR_W(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_mask(req_mask),
    .req_ack(req_ack), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
    .mem_dout(mem_dout), .mem_drive(mem_drive), .mem_cs_n(mem_cs_n),
    .mem_cs(mem_cs), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_be_n(mem_be_n), .mem_din(din_q)
  );

  // behavioural memory with timing bookkeeping
  logic [15:0] mem [DEPTH];
  logic [15:0] exp_mem [DEPTH];
  bit armed = 1'b0;
  time t_addr = 0, t_oe_fall = 0, t_oe_rise = 0, t_cs_fall = 0, t_we_fall = 0, t_dout = 0;
  int v_we = 0, v_cs = 0, v_drv = 0, wr_cnt = 0;

  always @(mem_addr) t_addr = $time;
  always @(mem_dout) t_dout = $time;
  always @(negedge mem_oe_n) t_oe_fall = $time;
  always @(posedge mem_oe_n) t_oe_rise = $time;
  always @(negedge mem_cs_n) t_cs_fall = $time;
  always @(posedge mem_cs_n) if (armed && ($time - t_cs_fall < 85)) v_cs++;
  always @(negedge mem_we_n) begin
    t_we_fall = $time;
    if (armed && !mem_oe_n) v_we++;
  end
  always @(posedge mem_we_n) begin
    if (armed) begin
      if ($time - t_we_fall < 60) v_we++;
      if ($time - t_dout < 40) v_we++;
      if ($time - t_addr < 70) v_we++;
      if (mem_cs_n || !mem_cs) v_we++;
      if (!mem_be_n[0]) mem[mem_addr][7:0]  = mem_dout[7:0];
      if (!mem_be_n[1]) mem[mem_addr][15:8] = mem_dout[15:8];
      wr_cnt++;
    end
  end
  always @(posedge mem_drive) if (armed && (!mem_oe_n || ($time - t_oe_rise < 30))) v_drv++;

  always @(negedge clk) begin
    logic [15:0] w;
    bit ok;
    ok = !mem_cs_n && mem_cs && !mem_oe_n && mem_we_n &&
         ($time - t_addr >= 85) && ($time - t_cs_fall >= 85) && ($time - t_oe_fall >= 35);
    w = ok ? mem[mem_addr] : ~mem[mem_addr];
    din_q <= {mem_be_n[1] ? 8'hA5 : w[15:8], mem_be_n[0] ? 8'h5A : w[7:0]};
  end

  int n_cmp = 0, n_bad = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic txn(input bit wr, input int a, input logic [15:0] d, input logic [1:0] m,
                     input int gap, input int exp_lat, input string tag,
                     output logic [15:0] rd);
    int lat, we_lo, oe_lo, cs_lo;
    bit setup_ok;
    repeat (gap) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = AW'(a); req_wdata = d; req_mask = m;
    lat = 0; we_lo = 0; oe_lo = 0; cs_lo = 0; setup_ok = 1'b1;
    do begin
      @(negedge clk);
      lat++;
      if (!mem_we_n) we_lo++;
      if (!mem_oe_n) oe_lo++;
      if (!mem_cs_n) cs_lo++;
      if (lat == 1 && wr && m != 0 && gap > 0) setup_ok = mem_we_n && mem_drive && mem_oe_n;
    end while (!req_ack && lat < 64);
    rd = rsp_rdata;
    req_valid = 1'b0;
    if (exp_lat > 0) chk(lat == exp_lat, tag, lat, exp_lat);
    if (gap > 0 && m != 0) begin
      if (wr) begin
        chk(we_lo == EXP_WP, "R4 pulse", we_lo, EXP_WP);
        chk(setup_ok, "R4 setup", setup_ok, 1);
        chk(oe_lo == 0, "R4 oe", oe_lo, 0);
      end else begin
        chk(oe_lo == EXP_RD, "R2 window", oe_lo, EXP_RD);
      end
    end
    if (m == 0) chk(cs_lo == 0 && we_lo == 0 && oe_lo == 0, "R6 pins", cs_lo + we_lo + oe_lo, 0);
    @(negedge clk);
    chk(!req_ack, "R7 pulse", req_ack, 0);
  endtask

  function automatic logic [15:0] pat1(input int a); return 16'((a * 16'h1357) ^ 16'hC3A5); endfunction
  function automatic logic [15:0] pat2(input int a); return 16'((a * 16'h2469) + 16'h0F1E); endfunction

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK * 150000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: got 1 expected 0");
    finish_run();
  end

  initial begin
    logic [15:0] rd, e, hold;
    int wr_before;
    for (int i = 0; i < DEPTH; i++) begin mem[i] = '0; exp_mem[i] = '0; end
    repeat (5) @(negedge clk);
    // R1: pins idle during reset
    chk(mem_cs_n && !mem_cs && mem_oe_n && mem_we_n && !mem_drive && mem_be_n == 2'b11 && !req_ack,
        "R1 reset", {mem_cs_n, mem_cs, mem_oe_n, mem_we_n, mem_drive, req_ack}, 6'b101100);
    rst_n = 1'b1;
    armed = 1'b1;
    repeat (4) @(negedge clk);
    chk(mem_cs_n && mem_oe_n && mem_we_n && !mem_drive && !req_ack, "R1 idle",
        {mem_cs_n, mem_oe_n, mem_we_n, mem_drive, req_ack}, 5'b11100);

    // full-width writes over every address (R4, R10)
    for (int a = 0; a < DEPTH; a++) begin
      txn(1'b1, a, pat1(a), 2'b11, 3, LAT_WR, "R4 latency", rd);
      exp_mem[a] = pat1(a);
    end
    // full-width reads (R2, R10)
    for (int a = 0; a < DEPTH; a++) begin
      txn(1'b0, a, '0, 2'b11, 3, LAT_RD, "R2 latency", rd);
      chk(rd == exp_mem[a], "R2 data", rd, exp_mem[a]);
    end
    // masked writes, lane per mask bit (R5)
    for (int a = 0; a < DEPTH; a++) begin
      logic [1:0] m;
      m = 2'((a % 3) + 1);
      txn(1'b1, a, pat2(a), m, 3, LAT_WR, "R5 latency", rd);
      if (m[0]) exp_mem[a][7:0]  = pat2(a) * 1'b1 & 16'h00FF | exp_mem[a][7:0] & 8'h00;
      if (m[1]) exp_mem[a][15:8] = pat2(a) >> 8;
    end
    // masked reads: disabled lane reads zero (R3, R5)
    for (int a = 0; a < DEPTH; a++) begin
      logic [1:0] m;
      m = 2'(((a + 1) % 3) + 1);
      txn(1'b0, a, '0, m, 3, LAT_RD, "R3 latency", rd);
      e = {m[1] ? exp_mem[a][15:8] : 8'h00, m[0] ? exp_mem[a][7:0] : 8'h00};
      chk(rd == e, "R3 lanes", rd, e);
    end
    // empty mask: immediate completion, no write (R6)
    wr_before = wr_cnt;
    for (int a = 0; a < 8; a++) begin
      txn(1'b1, a, 16'hFFFF, 2'b00, 3, 1, "R6 latency", rd);
      txn(1'b0, a, '0, 2'b00, 3, 1, "R6 latency", rd);
    end
    chk(wr_cnt == wr_before, "R6 no write", wr_cnt, wr_before);
    for (int a = 0; a < 8; a++) begin
      txn(1'b0, a, '0, 2'b11, 3, LAT_RD, "R6 latency", rd);
      chk(rd == exp_mem[a], "R6 contents", rd, exp_mem[a]);
    end
    // read result held across a write (R3)
    txn(1'b0, 9, '0, 2'b11, 3, LAT_RD, "R3 latency", hold);
    txn(1'b1, 10, 16'hBEEF, 2'b11, 3, LAT_WR, "R3 latency", rd);
    exp_mem[10] = 16'hBEEF;
    chk(rsp_rdata == hold, "R3 hold", rsp_rdata, hold);
    // back-to-back read/write alternation (R8, R9)
    for (int a = 16; a < 48; a++) begin
      txn(1'b0, a, '0, 2'b11, 0, 0, "R8", rd);
      chk(rd == exp_mem[a], "R8 data", rd, exp_mem[a]);
      txn(1'b1, a, ~rd, 2'b11, 0, 0, "R8", rd);
      exp_mem[a] = ~exp_mem[a];
    end
    for (int a = 16; a < 48; a++) begin
      txn(1'b0, a, '0, 2'b11, 0, 0, "R9", rd);
      chk(rd == exp_mem[a], "R9 data", rd, exp_mem[a]);
    end
    chk(v_drv == 0, "R8 turnaround", v_drv, 0);
    chk(v_we == 0, "R4 write timing", v_we, 0);
    chk(v_cs == 0, "R9 cycle length", v_cs, 0);
    finish_run();
  end
endmodule